// File: doc/BRIEF.md
# Receive Pulse Density Violation Detector

This block watches a received serial T1 bit stream and decides whether the stream meets the line's pulse density rule. One bit is offered per cycle in which the bit-valid strobe is high, and the block always accepts it. The stream has no back-pressure, so the block has no ready output. A bit presented while the strobe is low is never consumed and has no effect.

Two independent checks run on the accepted bits. A run-length check counts consecutive zeros. A sliding-window check keeps the last 192 accepted bits and counts the ones among them. Either check alone raises the violation. `pdv_status` is a level that stays high while either condition holds. `pdv_event` is a single-cycle pulse on each rising edge of the combined condition, meant to feed a receive alarm interrupt status bit held in separate status logic.

Top module: `pdv_detector`

## Requirements
- R1: After reset, `pdv_status` and `pdv_event` are both 0, and no bits are considered received.
- R2: The zero-run condition is true once 16 or more consecutive zeros have been accepted (more than 15); after exactly 15 consecutive zeros it is false.
- R3: Any accepted one (`bit_data`=1 with `bit_valid`=1) ends the zero run, so the zero-run condition is false after that bit.
- R4: The zero-run count saturates and does not wrap, so the zero-run condition stays true across arbitrarily long runs of zeros.
- R5: A cycle with `bit_valid`=0 changes no state, whatever the value of `bit_data`.
- R6: Once at least 192 bits have been accepted since reset, the density condition is true when the last 192 accepted bits hold fewer than 24 ones. With exactly 24 ones it is false.
- R7: The density condition is false until 192 bits have been accepted since reset.
- R8: Both outputs follow the same timing. `pdv_status` is the OR of the two conditions and is valid in the cycle after the clock edge that accepts a bit. `pdv_event` is high for exactly one cycle when that OR goes from 0 to 1, and does not repeat while the OR stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_valid | input | 1 | High when `bit_data` carries a received bit; every such bit is accepted |
| bit_data | input | 1 | Received line bit |
| pdv_event | output | 1 | One-cycle pulse on the onset of a violation |
| pdv_status | output | 1 | Level, high while a violation condition holds |

## Verification
The hardest state to reach from the ports is a density violation with no zero-run violation. It needs a full window of bits that are sparse but never sparse enough to leave 16 zeros in a row. The stimulus sends a one on every ninth bit, which gives 21 or 22 ones per window and runs of at most 8 zeros. It then moves to one in eight bits, which holds exactly 24 ones and sits on the boundary. The bench also runs a sparse pattern before the window has filled, so that an early density flag would show up, and interleaves idle cycles that carry garbage data.

// File: rtl/pdv_pkg.sv
package pdv_pkg;
  localparam int unsigned PDV_MAX_ZEROS = 15;   // longest legal zero run
  localparam int unsigned PDV_WINDOW    = 192;  // density window in bits
  localparam int unsigned PDV_MIN_ONES  = 24;   // fewest ones allowed per window

  typedef struct packed {
    logic zero_run;
    logic low_density;
  } pdv_cond_t;
endpackage

// File: rtl/pdv_zero_run.sv
module pdv_zero_run #(
  parameter int unsigned MAX_ZEROS = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid,
  input  logic bit_data,
  output logic run_viol
);
  localparam int unsigned SAT = MAX_ZEROS + 1;
  localparam int unsigned CW  = $clog2(SAT + 1);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else if (bit_valid) begin
      if (bit_data)                 run_cnt <= '0;
      else if (run_cnt != CW'(SAT)) run_cnt <= run_cnt + 1'b1;
    end
  end

  assign run_viol = (run_cnt == CW'(SAT));

  a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= CW'(SAT));
  a_r3_one_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && bit_data) |=> (run_cnt == '0));
  a_r5_idle_holds_run: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> $stable(run_cnt));
endmodule

// File: rtl/pdv_density_window.sv
module pdv_density_window #(
  parameter int unsigned WINDOW   = 192,
  parameter int unsigned MIN_ONES = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid,
  input  logic bit_data,
  output logic dens_viol
);
  localparam int unsigned CW = $clog2(WINDOW + 1);

  logic [WINDOW-1:0] hist;
  logic [CW-1:0]     ones_cnt;
  logic [CW-1:0]     fill_cnt;
  logic              filled;
  logic              oldest;

  assign oldest = hist[WINDOW-1];
  assign filled = (fill_cnt == CW'(WINDOW));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist     <= '0;
      ones_cnt <= '0;
      fill_cnt <= '0;
    end else if (bit_valid) begin
      hist     <= {hist[WINDOW-2:0], bit_data};
      ones_cnt <= ones_cnt + CW'(bit_data) - CW'(oldest);
      if (!filled) fill_cnt <= fill_cnt + 1'b1;
    end
  end

  assign dens_viol = filled && (ones_cnt < CW'(MIN_ONES));

  a_r6_ones_within_fill: assert property (@(posedge clk) disable iff (!rst_n)
    ones_cnt <= fill_cnt);
  a_r7_fill_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt <= CW'(WINDOW));
  a_r5_idle_holds_window: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> ($stable(ones_cnt) && $stable(fill_cnt)));
endmodule

// File: rtl/pdv_detector.sv
module pdv_detector
  import pdv_pkg::*;
#(
  parameter int unsigned MAX_ZEROS = PDV_MAX_ZEROS,
  parameter int unsigned WINDOW    = PDV_WINDOW,
  parameter int unsigned MIN_ONES  = PDV_MIN_ONES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid,
  input  logic bit_data,
  output logic pdv_event,
  output logic pdv_status
);
  pdv_cond_t cond;
  logic      any_q;
  logic      any_now;

  pdv_zero_run #(.MAX_ZEROS(MAX_ZEROS)) u_run (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_data(bit_data),
    .run_viol(cond.zero_run)
  );

  pdv_density_window #(.WINDOW(WINDOW), .MIN_ONES(MIN_ONES)) u_dens (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_data(bit_data),
    .dens_viol(cond.low_density)
  );

  assign any_now = cond.zero_run | cond.low_density;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) any_q <= 1'b0;
    else        any_q <= any_now;
  end

  assign pdv_status = any_now;
  assign pdv_event  = any_now & ~any_q;

  a_r8_event_single: assert property (@(posedge clk) disable iff (!rst_n)
    pdv_event |=> !pdv_event);
  a_r8_event_with_status: assert property (@(posedge clk) disable iff (!rst_n)
    pdv_event |-> pdv_status);
  a_r2_run_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    cond.zero_run |-> pdv_status);
  a_r6_density_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    cond.low_density |-> pdv_status);
endmodule

// File: tb/pdv_detector_tb_top.sv
module pdv_detector_tb_top;
  localparam int WIN = 192;
  localparam int MINONES = 24;
  localparam int MAXZ = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_valid = 1'b0;
  logic bit_data = 1'b0;
  logic pdv_event, pdv_status;

  always #10 clk = ~clk;

  pdv_detector dut_i (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_data(bit_data),
    .pdv_event(pdv_event), .pdv_status(pdv_status)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_req = "R1";

  // behavioural reference
  bit hist_q[$];
  int zrun = 0;
  int total = 0;
  bit m_cond = 0;
  bit m_prev = 0;

  function automatic bit model_cond();
    int ones = 0;
    foreach (hist_q[i]) ones += hist_q[i];
    return (zrun > MAXZ) || (total >= WIN && ones < MINONES);
  endfunction

  always @(posedge clk) begin
    cycles++;
    m_prev = m_cond;
    if (!rst_n) begin
      hist_q.delete(); zrun = 0; total = 0; m_cond = 0; m_prev = 0;
    end else begin
      if (bit_valid) begin
        hist_q.push_back(bit_data);
        if (hist_q.size() > WIN) void'(hist_q.pop_front());
        total++;
        zrun = bit_data ? 0 : zrun + 1;
      end
      m_cond = model_cond();
    end
  end

  task automatic check(string req, string what, bit got, bit exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %0b expected %0b at cycle %0d", req, what, got, exp, cycles);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(cur_req, "status (R8)", pdv_status, m_cond);
      check(cur_req, "event (R8)", pdv_event, m_cond && !m_prev);
    end
  end

  always @(negedge clk) begin
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic send(bit b);
    @(negedge clk); bit_valid = 1'b1; bit_data = b;
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_valid = 1'b0; bit_data = i[0];
    end
  endtask
  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; bit_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask
  task automatic pattern(int period, int n);
    for (int i = 0; i < n; i++) send((i % period) == 0);
  endtask
  task automatic settle();
    @(negedge clk); bit_valid = 1'b0; #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1", "status in reset", pdv_status, 1'b0);
    check("R1", "event in reset", pdv_event, 1'b0);
    rst_n = 1'b1;
    settle();
    check("R1", "status after reset", pdv_status, 1'b0);

    cur_req = "R2";
    for (int i = 0; i < 15; i++) send(1'b0);
    settle();
    check("R2", "15 zeros no violation", pdv_status, 1'b0);
    cur_req = "R3";
    send(1'b1);
    for (int i = 0; i < 15; i++) send(1'b0);
    settle();
    check("R3", "one restarts run", pdv_status, 1'b0);
    cur_req = "R2";
    send(1'b0);
    @(negedge clk); bit_valid = 1'b0; #1;
    check("R2", "16th zero event", pdv_event, 1'b1);
    check("R2", "16th zero status", pdv_status, 1'b1);

    cur_req = "R4";
    for (int i = 0; i < 300; i++) send(1'b0);
    settle();
    check("R4", "long run stays violated", pdv_status, 1'b1);
    check("R4", "no repeat event", pdv_event, 1'b0);

    cur_req = "R5";
    do_reset();
    for (int i = 0; i < 14; i++) send(1'b0);
    idle(20);
    #1;
    check("R5", "idle data ignored", pdv_status, 1'b0);
    send(1'b0);
    settle();
    check("R5", "run resumes, 15 zeros", pdv_status, 1'b0);
    send(1'b0);
    settle();
    check("R5", "run resumes, 16 zeros", pdv_status, 1'b1);

    cur_req = "R7";
    do_reset();
    pattern(9, 150);
    settle();
    check("R7", "sparse before fill", pdv_status, 1'b0);

    cur_req = "R6";
    pattern(9, 300);
    settle();
    check("R6", "one in nine violates", pdv_status, 1'b1);
    pattern(4, 200);
    settle();
    check("R6", "dense stream clears", pdv_status, 1'b0);
    pattern(8, 400);
    settle();
    check("R6", "exactly 24 ones legal", pdv_status, 1'b0);
    pattern(9, 400);
    settle();
    check("R6", "re-entry violates", pdv_status, 1'b1);

    cur_req = "R8";
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      if ((i % 7) == 3) idle(1);
      send(($urandom_range(0, 99) < ((i / 500) % 2 ? 11 : 30)) ? 1'b1 : 1'b0);
    end
    settle();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule